// File: doc/BRIEF.md
# Four-Channel Programmable Counter-Timer

This block holds four down-counter channels behind one byte-wide write port. Each channel is programmed with a control byte and then a reload constant. It then produces a periodic expiry pulse whose rate is a fixed fraction of either the system clock or an external trigger. In timer mode a channel counts the system clock after a fixed prescaler of 16 or 256, chosen per channel. In counter mode it counts the selected edge of its own trigger input, with no prescaler.

The trigger is brought into the clock domain by a two-flop synchroniser. A detected edge decrements the count on the following clock. The fastest trigger the block can follow is therefore one that toggles every clock, which gives one decrement every two clocks. Each time the count runs out, the channel reloads its constant and raises its expiry pin for exactly one clock. The result is a narrow-pulse rate reference, for example a 16x bit-rate clock for a serial receiver. Channels 0 to 2 have an expiry pin; channel 3 counts but has no pin.

Top module: `ctc_quad`

## Requirements
- R1: There are four independent channels, selected by `ch_addr[1:0]` while `cs` and `wr_en` are high. `zc_out[k]` is the expiry pin of channel k, for k = 0, 1 and 2. Programming or running one channel has no effect on the period of another.
- R2: A write to a channel that is not awaiting a constant is a control byte when bit 0 is 1. Its fields are: bit 6 mode (1 counter, 0 timer), bit 5 prescaler (1 gives 256, 0 gives 16), bit 4 trigger edge (1 rising, 0 falling), bit 2 constant-follows, bit 1 soft reset. Such a write with bit 0 = 0 is ignored, and any write with `cs` low is ignored.
- R3: In timer mode with prescaler P and constant N, the first expiry pulse is seen P*N clocks after the clock edge that captured the constant.
- R4: After a control byte with bit 2 set, the next write to that channel is taken as the constant, whatever its bit 0. That write restarts the count and the prescaler and starts the channel.
- R5: On expiry the channel reloads the same constant without software action, so pulses repeat with a period of P*N clocks in timer mode.
- R6: Each expiry pulse is high for exactly one clock.
- R7: In counter mode with rising edges selected and a trigger that toggles every clock, the pulse period is 2*N clocks.
- R8: A control byte with bit 1 set stops the channel. It then produces no pulses until a new constant is written.
- R9: A constant of 0 counts as 256.
- R10: In counter mode only the selected trigger edge counts. With N = 1 and falling edges selected, a rising trigger edge gives no pulse and the following falling edge gives one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Block select for writes |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| ch_addr | input | 2 | Channel index of the write |
| wr_data | input | 8 | Control byte or reload constant |
| trig | input | 4 | External trigger per channel, asynchronous |
| zc_out | output | 3 | Expiry pulses of channels 0 to 2 |

## Verification
The assertions assume that writes are synchronous and last one clock per access. They also assume that trigger inputs are either steady or move no faster than one change per clock. Under those conditions a pulse can never be two clocks long, and an idle channel's count cannot move unless it is written. The bench drives every write and every trigger change from the falling clock edge, one write per task step. Its toggling trigger changes at most once per clock, so the stimulus stays inside these assumptions.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  localparam int NCH      = 4;
  localparam int NOUT     = 3;
  localparam int DW       = 8;
  localparam int PRE_LO   = 16;
  localparam int PRE_HI   = 256;
  localparam int PRE_W    = $clog2(PRE_HI);

  // control byte field positions
  localparam int B_CTRL   = 0;
  localparam int B_SRST   = 1;
  localparam int B_TCF    = 2;
  localparam int B_RISE   = 4;
  localparam int B_P256   = 5;
  localparam int B_CNTM   = 6;

  typedef struct packed {
    logic cnt_mode;
    logic pre256;
    logic rise;
  } ch_cfg_t;
endpackage

// File: rtl/ctc_trig_sync.sv
module ctc_trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic rise_sel,
  output logic edge_hit
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= trig;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_comb begin
    if (rise_sel) edge_hit = s2_q & ~s3_q;
    else          edge_hit = ~s2_q & s3_q;
  end
endmodule

// File: rtl/ctc_prescale.sv
module ctc_prescale
  import ctc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic sel_hi,
  output logic tick
);
  localparam logic [PRE_W-1:0] LIM_LO = PRE_W'(PRE_LO - 1);
  localparam logic [PRE_W-1:0] LIM_HI = PRE_W'(PRE_HI - 1);

  logic [PRE_W-1:0] pc_q, pc_d;
  logic [PRE_W-1:0] lim;

  always_comb begin
    lim  = sel_hi ? LIM_HI : LIM_LO;
    tick = en & ~clr & (pc_q == lim);
    pc_d = pc_q;
    if (clr)       pc_d = '0;
    else if (tick) pc_d = '0;
    else if (en)   pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/ctc_channel.sv
module ctc_channel
  import ctc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [DW-1:0] wr_data,
  input  logic          trig,
  output logic          zc,
  output logic          running,
  output logic          pending,
  output logic [DW-1:0] count
);
  ch_cfg_t       cfg_q, cfg_d;
  logic          run_q, run_d;
  logic          pend_q, pend_d;
  logic [DW-1:0] tc_q, tc_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          zc_q, zc_d;
  logic          load;
  logic          edge_hit;
  logic          pre_tick;
  logic          tick;

  ctc_trig_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (trig),
    .rise_sel (cfg_q.rise),
    .edge_hit (edge_hit)
  );

  ctc_prescale u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (load | ~run_q),
    .en     (run_q & ~cfg_q.cnt_mode),
    .sel_hi (cfg_q.pre256),
    .tick   (pre_tick)
  );

  always_comb begin
    load  = wr_hit & pend_q;
    tick  = run_q & (cfg_q.cnt_mode ? edge_hit : pre_tick);
    cfg_d = cfg_q;
    run_d = run_q;
    pend_d = pend_q;
    tc_d  = tc_q;
    cnt_d = cnt_q;
    zc_d  = 1'b0;
    if (load) begin
      tc_d   = wr_data;
      cnt_d  = wr_data;
      run_d  = 1'b1;
      pend_d = 1'b0;
    end else if (wr_hit && wr_data[B_CTRL]) begin
      cfg_d.cnt_mode = wr_data[B_CNTM];
      cfg_d.pre256   = wr_data[B_P256];
      cfg_d.rise     = wr_data[B_RISE];
      pend_d         = wr_data[B_TCF];
      if (wr_data[B_SRST]) run_d = 1'b0;
    end else if (tick) begin
      if (cnt_q == DW'(1)) begin
        cnt_d = tc_q;
        zc_d  = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      tc_q   <= '0;
      cnt_q  <= '0;
      zc_q   <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      run_q  <= run_d;
      pend_q <= pend_d;
      tc_q   <= tc_d;
      cnt_q  <= cnt_d;
      zc_q   <= zc_d;
    end
  end

  assign zc      = zc_q;
  assign running = run_q;
  assign pending = pend_q;
  assign count   = cnt_q;
endmodule

// File: rtl/ctc_quad.sv
module ctc_quad
  import ctc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs,
  input  logic            wr_en,
  input  logic [1:0]      ch_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [NCH-1:0]  trig,
  output logic [NOUT-1:0] zc_out
);
  logic [NCH-1:0]         zc_all;
  logic [NCH-1:0]         run_all;
  logic [NCH-1:0]         pend_all;
  logic [NCH-1:0][DW-1:0] cnt_all;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [1:0] IDX = 2'(i);
    logic hit;
    assign hit = cs & wr_en & (ch_addr == IDX);

    ctc_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (hit),
      .wr_data (wr_data),
      .trig    (trig[i]),
      .zc      (zc_all[i]),
      .running (run_all[i]),
      .pending (pend_all[i]),
      .count   (cnt_all[i])
    );
  end

  assign zc_out = zc_all[NOUT-1:0];
endmodule

// File: rtl/ctc_quad_chk.sv
module ctc_quad_chk
  import ctc_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cs,
  input logic                   wr_en,
  input logic [1:0]             ch_addr,
  input logic [DW-1:0]          wr_data,
  input logic [NCH-1:0]         zc_all,
  input logic [NCH-1:0]         run_all,
  input logic [NCH-1:0]         pend_all,
  input logic [NCH-1:0][DW-1:0] cnt_all
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    logic hit;
    assign hit = cs & wr_en & (ch_addr == 2'(i));

    AST_ZC_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      zc_all[i] |=> !zc_all[i]);                                          // R6
    AST_TC_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && pend_all[i]) |=> (run_all[i] && !pend_all[i]));              // R4
    AST_SRST_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !pend_all[i] && wr_data[B_CTRL] && wr_data[B_SRST])
        |=> (!run_all[i] && !zc_all[i]));                                  // R8
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_all[i] && !hit) |=> ($stable(cnt_all[i]) && !zc_all[i]));      // R8
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !pend_all[i]) |=> !pend_all[i]);                            // R2
  end
endmodule

bind ctc_quad ctc_quad_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs       (cs),
  .wr_en    (wr_en),
  .ch_addr  (ch_addr),
  .wr_data  (wr_data),
  .zc_all   (zc_all),
  .run_all  (run_all),
  .pend_all (pend_all),
  .cnt_all  (cnt_all)
);

// File: tb/ctc_quad_tb.sv
module ctc_quad_tb;
  localparam logic [7:0] CW = 8'h01, SRST = 8'h02, TCF = 8'h04,
                         RISE = 8'h10, P256 = 8'h20, CNTM = 8'h40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] ch_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [3:0] man_trig = 4'd0;
  logic [3:0] tog_en = 4'd0;
  logic       tog = 1'b0;
  logic [3:0] trig;
  logic [2:0] zc_out;
  int checks = 0, failures = 0, cyc = 0;

  assign trig = man_trig | (tog_en & {4{tog}});

  always #10 clk = ~clk;
  always @(negedge clk) tog <= ~tog;

  ctc_quad u_dut (.clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en),
    .ch_addr(ch_addr), .wr_data(wr_data), .trig(trig), .zc_out(zc_out));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual cyc=%0d expected <150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    cs = sel; wr_en = 1'b1; ch_addr = 2'(ch); wr_data = d;
    @(negedge clk);
    cs = 1'b0; wr_en = 1'b0; wr_data = 8'd0;
  endtask

  // clocks from the capture edge of the last write until zc seen high
  task automatic wait_zc(input int ch, input int lim, output int n);
    n = 0;
    for (int k = 0; k < lim; k++) begin
      @(negedge clk);
      n++;
      if (zc_out[ch]) return;
    end
    n = -1;
  endtask

  // gap between two pulses; also checks pulse width
  task automatic period(input string req, input int ch, input int exp);
    int n, w;
    wait_zc(ch, 2 * exp + 600, n);
    @(negedge clk);
    w = zc_out[ch] ? 2 : 1;
    check("R6 pulse width", w, 1);
    wait_zc(ch, 2 * exp + 600, n);
    check(req, (n < 0) ? -1 : n + 1, exp);
  endtask

  task automatic quiet(input string req, input int ch, input int len);
    int seen = 0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (zc_out[ch]) seen++;
    end
    check(req, seen, 0);
  endtask

  task automatic t_reset();
    check("R1 reset outputs", int'(zc_out), 0);
  endtask

  task automatic t_timer();
    int n;
    wr(0, CW | TCF);
    wr(0, 8'd3);
    wait_zc(0, 2000, n);
    check("R3 first pulse P16 N3", n, 48);
    period("R5 reload period P16 N3", 0, 48);
    wr(2, CW | TCF | P256);
    wr(2, 8'd2);
    wait_zc(2, 2000, n);
    check("R3 first pulse P256 N2", n, 512);
    period("R1 ch0 unaffected by ch2", 0, 48);
  endtask

  task automatic t_ignore();
    int n;
    wr(0, 8'h06);                   // bit0 clear: ignored
    period("R2 bit0-clear write ignored", 0, 48);
    wr(0, CW | TCF);
    wr(0, 8'd7, 1'b0);              // cs low: ignored
    wr(0, 8'd4);
    wait_zc(0, 2000, n);
    check("R2 cs-low write ignored, R4 load", n, 64);
  endtask

  task automatic t_tc_odd_and_zero();
    int n;
    wr(0, CW | TCF);
    wr(0, 8'd5);                    // bit0 set, still a constant
    wait_zc(0, 2000, n);
    check("R4 constant with bit0 set", n, 80);
    wr(0, CW | TCF);
    wr(0, 8'd0);
    wait_zc(0, 9000, n);
    check("R9 zero constant is 256", n, 4096);
  endtask

  task automatic t_srst();
    int n;
    wr(0, CW | SRST);
    quiet("R8 idle after soft reset", 0, 300);
    wr(0, CW | TCF);
    wr(0, 8'd2);
    wait_zc(0, 2000, n);
    check("R8 restarts on new constant", n, 32);
    wr(2, CW | SRST);
  endtask

  task automatic t_counter();
    wr(1, CW | TCF | CNTM | RISE);
    wr(1, 8'd3);
    tog_en[1] = 1'b1;
    period("R7 counter period N3", 1, 6);
    period("R7 counter period N3 repeat", 1, 6);
    tog_en[1] = 1'b0;
  endtask

  task automatic t_edge();
    int n;
    man_trig[1] = 1'b0;
    wr(1, CW | SRST | TCF | CNTM);  // falling edges
    repeat (4) @(negedge clk);
    wr(1, 8'd1);
    man_trig[1] = 1'b1;
    quiet("R10 rising edge ignored", 1, 8);
    man_trig[1] = 1'b0;
    wait_zc(1, 10, n);
    check("R10 falling edge counted", (n > 0) ? 1 : 0, 1);
    wr(1, CW | TCF | CNTM | RISE);
    wr(1, 8'd1);
    man_trig[1] = 1'b1;
    wait_zc(1, 10, n);
    check("R10 rising edge selected", (n > 0) ? 1 : 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_timer();
    t_ignore();
    t_tc_odd_and_zero();
    t_srst();
    t_counter();
    t_edge();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule